// File: doc/BRIEF.md
# Register-Write Command Packer

The packer turns a stream of register-write and control requests into 64-bit instructions and stores them, one 32-bit dword per cycle, into a command memory addressed in dwords. A downstream engine later fetches and executes that memory. Each request is a write (20-bit register offset, 32-bit value, 32-bit mask) or a control command: no-op, interrupt, microsecond wait, vblank-count wait, or finish.

Consecutive full-mask writes to the same register are merged into one indexed-burst instruction. The first such repeat goes back and rewrites the plain write already stored. Later repeats append their value, update the burst count in place, and keep the dword after the last value zero so that the next instruction still starts on an even index.

The packer keeps the free position, exported as a byte tail. It drops any request that would not fit and signals the drop with a pulse. On finish it zero-fills up to the next 64-byte boundary. Requests use a valid/ready handshake. `req_ready` is low while stored dwords are still being written out.

Top module: `regwr_packer`

## Requirements
- R1: Every instruction occupies two dwords starting at an even index. The lower dword holds data. The upper dword holds the opcode in bits 31:24, the byte enables in bits 23:20 and the register offset in bits 19:0. A write request (req_kind 0) uses opcode 0x01.
- R2: The byte enable of a write has bit n set exactly when any bit of mask byte lane n (bits 8n+7:8n) is set.
- R3: A no-op (req_kind 1, also kinds 6 and 7) stores opcode 0x00 with zero data. An interrupt (kind 2) stores opcode 0x07 with zero data. A microsecond wait (kind 3) stores opcode 0x02 and a vblank wait (kind 4) stores opcode 0x04, each with req_data as the lower dword. Their byte-enable and offset fields are zero.
- R4: A full-mask write to the same offset as an immediately preceding full-enable plain write converts that instruction in place. At its start index s it writes count 2 to s, {0x09, 4'h0, offset} to s+1, the earlier value to s+2 and the new value to s+3. The free position becomes s+4.
- R5: A full-mask write to the offset of an immediately preceding indexed burst stores the value at the free position and advances it by one. It then writes the incremented count back to the burst's first dword. If the new free position is odd, it writes zero at that index.
- R6: A write never merges when its mask is not all ones, when its offset differs, when the previous instruction is not a write, when it is the first request after reset, or when it is the first request after a finish. Such a write starts a fresh instruction at the free position rounded up to even.
- R7: A non-finish request accepted while the free position exceeds DEPTH_DW-2 is dropped. Nothing is written, the tail stays unchanged, and `ovf_drop` is high for the one cycle after acceptance.
- R8: Finish rounds the free position up to a multiple of 16 dwords and writes zero to every dword in the gap. An already aligned position writes nothing.
- R9: `tail_bytes` equals four times the free position. It is zero after reset and takes its new value in the cycle after acceptance.
- R10: `req_ready` is low on every cycle that `mem_we` is high. At most one dword is written per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Packer idle and able to accept |
| req_kind | input | 3 | 0 write, 1 no-op, 2 interrupt, 3 usec wait, 4 vblank wait, 5 finish |
| req_ofs | input | 20 | Register offset for writes |
| req_data | input | 32 | Write value or wait count |
| req_mask | input | 32 | Write bit mask, reduced to byte enables |
| mem_we | output | 1 | Command memory write strobe |
| mem_idx | output | IDX_W | Dword index written |
| mem_wdata | output | 32 | Dword written |
| tail_bytes | output | IDX_W+3 | Free position in bytes |
| ovf_drop | output | 1 | One-cycle pulse for a dropped request |

## Verification
The checker assumes reset is low before the first edge. It also assumes the meaning of req_kind is fixed: only code 5 is a finish. Its tail-growth property depends on reset being the only thing that lowers the free position.

The bench holds each request steady until it sees ready. It uses only offsets within 20 bits and draws kinds from the defined codes. It sends runs of the same offset with full masks to reach both merge paths. It fills the memory with no-ops to reach the overflow edge. It leaves stale contents in the memory across resets, so that a false merge after reset would show.

// File: rtl/regwr_pkg.sv
package regwr_pkg;
   typedef enum logic [2:0] {
      RQ_WRITE    = 3'd0,
      RQ_NOOP     = 3'd1,
      RQ_IRQ      = 3'd2,
      RQ_WAIT_US  = 3'd3,
      RQ_WAIT_VBL = 3'd4,
      RQ_FINISH   = 3'd5
   } req_kind_e;

   localparam logic [7:0] OP_NOOP     = 8'h00;
   localparam logic [7:0] OP_WRITE    = 8'h01;
   localparam logic [7:0] OP_WAIT_US  = 8'h02;
   localparam logic [7:0] OP_WAIT_VBL = 8'h04;
   localparam logic [7:0] OP_IRQ      = 8'h07;
   localparam logic [7:0] OP_BURST    = 8'h09;

   localparam int OFS_W    = 20;
   localparam int LANES    = 4;
   localparam int SCRIPT_N = 4;
endpackage

// File: rtl/regwr_lane_en.sv
module regwr_lane_en #(
   parameter int LANES = 4
) (
   input  logic [LANES*8-1:0] mask,
   output logic [LANES-1:0]   be
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign be[g] = |mask[g*8 +: 8];
   end
endmodule

// File: rtl/regwr_planner.sv
module regwr_planner
   import regwr_pkg::*;
#(
   parameter int DEPTH_DW = 256,
   parameter int FILL_DW  = 16,
   localparam int IDX_W   = $clog2(DEPTH_DW),
   localparam int POS_W   = IDX_W + 1
) (
   input  logic [2:0]                      kind,
   input  logic [OFS_W-1:0]                ofs,
   input  logic [31:0]                     data,
   input  logic [LANES-1:0]                be,
   input  logic [POS_W-1:0]                free_pos,
   input  logic                            hv,
   input  logic [31:0]                     hi,
   input  logic [31:0]                     lo,
   input  logic [IDX_W-1:0]                st,
   output logic                            drop,
   output logic [2:0]                      n,
   output logic [SCRIPT_N-1:0][IDX_W-1:0]  idx,
   output logic [SCRIPT_N-1:0][31:0]       dat,
   output logic [POS_W-1:0]                nxt_pos,
   output logic                            nxt_hv,
   output logic [31:0]                     nxt_hi,
   output logic [31:0]                     nxt_lo,
   output logic [IDX_W-1:0]                nxt_st
);
   localparam logic [POS_W-1:0] DROP_ABOVE = POS_W'(DEPTH_DW - 2);
   localparam logic [POS_W-1:0] FILL_M1    = POS_W'(FILL_DW - 1);

   req_kind_e         k;
   logic              full, same, was_plain, was_burst;
   logic [POS_W-1:0]  ev, al;
   logic [IDX_W-1:0]  p, e;
   logic [7:0]        op;
   logic [31:0]       flo;

   assign k         = req_kind_e'(kind);
   assign full      = (be == {LANES{1'b1}});
   assign same      = hv && (hi[OFS_W-1:0] == ofs);
   assign was_plain = (hi[31:20] == {OP_WRITE, 4'hF});
   assign was_burst = (hi[31:24] == OP_BURST);
   assign ev        = free_pos + POS_W'(free_pos[0]);
   assign al        = (free_pos + FILL_M1) & ~FILL_M1;
   assign p         = free_pos[IDX_W-1:0];
   assign e         = ev[IDX_W-1:0];

   always_comb begin
      op  = OP_NOOP;
      flo = '0;
      case (k)
         RQ_WRITE:    begin op = OP_WRITE;    flo = data; end
         RQ_IRQ:      op = OP_IRQ;
         RQ_WAIT_US:  begin op = OP_WAIT_US;  flo = data; end
         RQ_WAIT_VBL: begin op = OP_WAIT_VBL; flo = data; end
         default:     op = OP_NOOP;
      endcase
   end

   always_comb begin
      drop    = 1'b0;
      n       = 3'd0;
      idx     = '0;
      dat     = '0;
      nxt_pos = free_pos;
      nxt_hv  = hv;
      nxt_hi  = hi;
      nxt_lo  = lo;
      nxt_st  = st;
      if (k == RQ_FINISH) begin
         nxt_pos = al;
         nxt_hv  = 1'b0;
      end else if (free_pos > DROP_ABOVE) begin
         drop = 1'b1;
      end else if (k == RQ_WRITE && full && same && was_plain) begin
         n      = 3'd4;
         idx[0] = st;              dat[0] = 32'd2;
         idx[1] = st + IDX_W'(1);  dat[1] = {OP_BURST, 4'h0, ofs};
         idx[2] = st + IDX_W'(2);  dat[2] = lo;
         idx[3] = st + IDX_W'(3);  dat[3] = data;
         nxt_pos = {1'b0, st} + POS_W'(4);
         nxt_hi  = {OP_BURST, 4'h0, ofs};
         nxt_lo  = 32'd2;
      end else if (k == RQ_WRITE && full && same && was_burst) begin
         n      = free_pos[0] ? 3'd2 : 3'd3;
         idx[0] = p;               dat[0] = data;
         idx[1] = st;              dat[1] = lo + 32'd1;
         idx[2] = p + IDX_W'(1);   dat[2] = 32'd0;
         nxt_pos = free_pos + POS_W'(1);
         nxt_lo  = lo + 32'd1;
      end else begin
         n      = 3'd2;
         idx[0] = e;               dat[0] = flo;
         idx[1] = e + IDX_W'(1);
         dat[1] = (k == RQ_WRITE) ? {op, be, ofs} : {op, 24'h0};
         nxt_pos = ev + POS_W'(2);
         nxt_hv  = 1'b1;
         nxt_hi  = dat[1];
         nxt_lo  = flo;
         nxt_st  = e;
      end
   end
endmodule

// File: rtl/regwr_packer.sv
module regwr_packer
   import regwr_pkg::*;
#(
   parameter int DEPTH_DW = 256,
   parameter int FILL_DW  = 16,
   localparam int IDX_W   = $clog2(DEPTH_DW),
   localparam int POS_W   = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_kind,
   input  logic [19:0]       req_ofs,
   input  logic [31:0]       req_data,
   input  logic [31:0]       req_mask,
   output logic              mem_we,
   output logic [IDX_W-1:0]  mem_idx,
   output logic [31:0]       mem_wdata,
   output logic [POS_W+1:0]  tail_bytes,
   output logic              ovf_drop
);
   if (DEPTH_DW < 16 || (DEPTH_DW & (DEPTH_DW - 1)) != 0)
      $error("DEPTH_DW must be a power of two of at least 16");
   if (FILL_DW < 2 || (FILL_DW & (FILL_DW - 1)) != 0 || FILL_DW > DEPTH_DW)
      $error("FILL_DW must be a power of two between 2 and DEPTH_DW");

   typedef enum logic [1:0] {S_IDLE, S_EMIT, S_FILL} state_e;

   state_e                          st_q;
   logic [POS_W-1:0]                pos_q, fill_q;
   logic                            hv_q;
   logic [31:0]                     hi_q, lo_q;
   logic [IDX_W-1:0]                hs_q;
   logic [SCRIPT_N-1:0][IDX_W-1:0]  sc_idx_q;
   logic [SCRIPT_N-1:0][31:0]       sc_dat_q;
   logic [2:0]                      sc_n_q;
   logic [1:0]                      sc_ptr_q;
   logic                            ovf_q;

   logic [LANES-1:0]                be;
   logic                            drop, nxt_hv;
   logic [2:0]                      n;
   logic [SCRIPT_N-1:0][IDX_W-1:0]  idx;
   logic [SCRIPT_N-1:0][31:0]       dat;
   logic [POS_W-1:0]                nxt_pos;
   logic [31:0]                     nxt_hi, nxt_lo;
   logic [IDX_W-1:0]                nxt_st;
   logic                            accept, is_fin;

   regwr_lane_en #(.LANES(LANES)) u_lane (.mask(req_mask), .be(be));

   regwr_planner #(.DEPTH_DW(DEPTH_DW), .FILL_DW(FILL_DW)) u_plan (
      .kind(req_kind), .ofs(req_ofs), .data(req_data), .be(be),
      .free_pos(pos_q), .hv(hv_q), .hi(hi_q), .lo(lo_q), .st(hs_q),
      .drop(drop), .n(n), .idx(idx), .dat(dat),
      .nxt_pos(nxt_pos), .nxt_hv(nxt_hv), .nxt_hi(nxt_hi),
      .nxt_lo(nxt_lo), .nxt_st(nxt_st)
   );

   assign req_ready = (st_q == S_IDLE);
   assign accept    = req_valid && req_ready;
   assign is_fin    = (req_kind_e'(req_kind) == RQ_FINISH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         pos_q    <= '0;
         fill_q   <= '0;
         hv_q     <= 1'b0;
         hi_q     <= '0;
         lo_q     <= '0;
         hs_q     <= '0;
         sc_idx_q <= '0;
         sc_dat_q <= '0;
         sc_n_q   <= '0;
         sc_ptr_q <= '0;
         ovf_q    <= 1'b0;
      end else begin
         ovf_q <= 1'b0;
         case (st_q)
            S_IDLE: if (accept) begin
               ovf_q <= drop;
               pos_q <= nxt_pos;
               hv_q  <= nxt_hv;
               hi_q  <= nxt_hi;
               lo_q  <= nxt_lo;
               hs_q  <= nxt_st;
               if (is_fin) begin
                  fill_q <= pos_q;
                  if (nxt_pos != pos_q) st_q <= S_FILL;
               end else if (!drop) begin
                  sc_idx_q <= idx;
                  sc_dat_q <= dat;
                  sc_n_q   <= n;
                  sc_ptr_q <= '0;
                  st_q     <= S_EMIT;
               end
            end
            S_EMIT: begin
               sc_ptr_q <= sc_ptr_q + 2'd1;
               if ({1'b0, sc_ptr_q} == sc_n_q - 3'd1) st_q <= S_IDLE;
            end
            S_FILL: begin
               fill_q <= fill_q + POS_W'(1);
               if (fill_q + POS_W'(1) == pos_q) st_q <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign mem_we     = (st_q != S_IDLE);
   assign mem_idx    = (st_q == S_EMIT) ? sc_idx_q[sc_ptr_q] : fill_q[IDX_W-1:0];
   assign mem_wdata  = (st_q == S_EMIT) ? sc_dat_q[sc_ptr_q] : 32'd0;
   assign tail_bytes = {pos_q, 2'b00};
   assign ovf_drop   = ovf_q;
endmodule

// File: rtl/regwr_packer_chk.sv
module regwr_packer_chk #(
   parameter int DEPTH_DW = 256,
   localparam int IDX_W   = $clog2(DEPTH_DW),
   localparam int TAIL_W  = IDX_W + 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [2:0]        req_kind,
   input logic              mem_we,
   input logic [IDX_W-1:0]  mem_idx,
   input logic [TAIL_W-1:0] tail_bytes,
   input logic              ovf_drop
);
   localparam logic [TAIL_W-1:0] FULL_TAIL = TAIL_W'(DEPTH_DW * 4);
   localparam logic [TAIL_W-1:0] DROP_TAIL = TAIL_W'((DEPTH_DW - 2) * 4);

   assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !req_ready);

   assert_drop_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_drop |-> (!mem_we && $stable(tail_bytes) && tail_bytes > DROP_TAIL));

   assert_tail_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tail_bytes >= $past(tail_bytes));

   assert_tail_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tail_bytes <= FULL_TAIL);

   assert_finish_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_kind == 3'd5) |=> (tail_bytes[5:0] == 6'd0));

   assert_write_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ({1'b0, mem_idx, 2'b00} <= tail_bytes));
endmodule

bind regwr_packer regwr_packer_chk #(.DEPTH_DW(DEPTH_DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_kind(req_kind), .mem_we(mem_we), .mem_idx(mem_idx),
   .tail_bytes(tail_bytes), .ovf_drop(ovf_drop)
);

// File: tb/regwr_packer_tb.sv
module regwr_packer_tb;
   localparam int DEPTH = 256;
   localparam int IW    = $clog2(DEPTH);
   localparam logic [31:0] STALE = 32'hDEAD_BEEF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [2:0]  req_kind = '0;
   logic [19:0] req_ofs = '0;
   logic [31:0] req_data = '0, req_mask = '0;
   logic mem_we;
   logic [IW-1:0] mem_idx;
   logic [31:0] mem_wdata;
   logic [IW+2:0] tail_bytes;
   logic ovf_drop;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [31:0] dut_mem [DEPTH];
   logic [31:0] m_mem [DEPTH];
   int m_pos, m_st, m_prev;
   logic [19:0] m_ofs;
   logic [31:0] m_val, m_cnt;

   always #4 clk = ~clk;

   regwr_packer u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_ofs(req_ofs), .req_data(req_data),
      .req_mask(req_mask), .mem_we(mem_we), .mem_idx(mem_idx),
      .mem_wdata(mem_wdata), .tail_bytes(tail_bytes), .ovf_drop(ovf_drop)
   );

   always @(posedge clk) if (mem_we) dut_mem[mem_idx] <= mem_wdata;

   function automatic logic [3:0] lanes(input logic [31:0] m);
      return {|m[31:24], |m[23:16], |m[15:8], |m[7:0]};
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
      end
   endtask

   // model, built from the requirement list (prev: 0 none, 1 full write, 2 burst, 3 other)
   task automatic model(input int kind, input logic [19:0] ofs, input logic [31:0] data,
                        input logic [31:0] mask, output bit drop);
      logic [3:0] be;
      drop = 0;
      be = lanes(mask);
      if (kind == 5) begin
         while (m_pos % 16 != 0) begin m_mem[m_pos] = 0; m_pos++; end
         m_prev = 0;
      end else if (m_pos > DEPTH - 2) begin
         drop = 1;
      end else if (kind == 0 && be == 4'hF && m_prev == 1 && m_ofs == ofs) begin
         m_mem[m_st] = 2; m_mem[m_st+1] = {8'h09, 4'h0, ofs};
         m_mem[m_st+2] = m_val; m_mem[m_st+3] = data;
         m_pos = m_st + 4; m_cnt = 2; m_prev = 2;
      end else if (kind == 0 && be == 4'hF && m_prev == 2 && m_ofs == ofs) begin
         m_mem[m_pos] = data; m_pos++; m_cnt++;
         m_mem[m_st] = m_cnt;
         if (m_pos % 2 == 1) m_mem[m_pos] = 0;
      end else begin
         logic [31:0] lo, hi;
         if (m_pos % 2 == 1) m_pos++;
         case (kind)
            0: begin lo = data; hi = {8'h01, be, ofs}; end
            2: begin lo = 0;    hi = 32'h0700_0000; end
            3: begin lo = data; hi = 32'h0200_0000; end
            4: begin lo = data; hi = 32'h0400_0000; end
            default: begin lo = 0; hi = 32'h0; end
         endcase
         m_mem[m_pos] = lo; m_mem[m_pos+1] = hi;
         m_st = m_pos; m_pos += 2; m_val = lo; m_ofs = ofs;
         m_prev = (kind == 0 && be == 4'hF) ? 1 : 3;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_pos = 0; m_prev = 0; m_st = 0; m_cnt = 0; m_val = 0; m_ofs = 0;
      @(negedge clk);
      chk(req_ready && tail_bytes == 0 && !mem_we && !ovf_drop, "R9", "reset state",
          {req_ready, mem_we, ovf_drop, 16'(tail_bytes)}, 32'h4_0000);
   endtask

   task automatic req(input int kind, input logic [19:0] ofs, input logic [31:0] data,
                      input logic [31:0] mask, input string tag);
      bit ed;
      int bad;
      model(kind, ofs, data, mask, ed);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_kind = 3'(kind); req_ofs = ofs;
      req_data = data; req_mask = mask;
      @(negedge clk);
      req_valid = 1'b0;
      chk(ovf_drop == ed, ed ? "R7" : tag, "drop pulse", 32'(ovf_drop), 32'(ed));
      while (!req_ready) @(negedge clk);
      chk(tail_bytes == (m_pos * 4), tag, "tail R9", 32'(tail_bytes), m_pos * 4);
      bad = -1;
      for (int i = 0; i < DEPTH; i++)
         if (bad < 0 && dut_mem[i] !== m_mem[i]) bad = i;
      if (bad < 0) chk(1, tag, "memory", 0, 0);
      else chk(0, tag, $sformatf("memory dword %0d", bad), dut_mem[bad], m_mem[bad]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < DEPTH; i++) begin dut_mem[i] = STALE; m_mem[i] = STALE; end
      do_reset();
      // directed corner cases
      req(0, 20'h00123, 32'h11, 32'hFFFF_FFFF, "R1");
      req(0, 20'h00123, 32'h22, 32'hFFFF_FFFF, "R4");
      req(0, 20'h00123, 32'h33, 32'hFFFF_FFFF, "R5");
      req(0, 20'h00123, 32'h44, 32'hFFFF_FFFF, "R5");
      req(0, 20'h00123, 32'h55, 32'h00FF_0000, "R2");
      req(0, 20'h00123, 32'h66, 32'hFFFF_FFFF, "R6");
      req(0, 20'h00456, 32'h77, 32'hFFFF_FFFF, "R6");
      req(0, 20'h00456, 32'h88, 32'h8000_0001, "R2");
      req(1, 20'h0, 32'h0, 32'h0, "R3");
      req(2, 20'h0, 32'h0, 32'h0, "R3");
      req(3, 20'h0, 32'h1234, 32'h0, "R3");
      req(4, 20'h0, 32'h3, 32'h0, "R3");
      req(0, 20'h00456, 32'h99, 32'hFFFF_FFFF, "R6");
      req(5, 20'h0, 32'h0, 32'h0, "R8");
      req(0, 20'h00456, 32'hAA, 32'hFFFF_FFFF, "R6");
      req(5, 20'h0, 32'h0, 32'h0, "R8");
      // first request after reset sees stale memory but must not merge
      do_reset();
      req(0, 20'h00456, 32'hBB, 32'hFFFF_FFFF, "R6");
      req(5, 20'h0, 32'h0, 32'h0, "R8");
      req(5, 20'h0, 32'h0, 32'h0, "R8");
      while (m_pos < DEPTH) req(1, 20'h0, 32'h0, 32'h0, "R7");
      req(1, 20'h0, 32'h0, 32'h0, "R7");
      req(0, 20'h00456, 32'hCC, 32'hFFFF_FFFF, "R7");
      req(5, 20'h0, 32'h0, 32'h0, "R8");
      // constrained random phases
      for (int ph = 0; ph < 3; ph++) begin
         do_reset();
         for (int k = 0; k < 200; k++) begin
            int r, kind;
            logic [19:0] o;
            logic [31:0] mk;
            r = int'($urandom % 16);
            kind = (r < 10) ? 0 : (r == 15) ? 5 : r - 9;
            case ($urandom % 3)
               0: o = 20'h00100;
               1: o = 20'h00104;
               default: o = 20'hFFFFC;
            endcase
            case ($urandom % 5)
               0: mk = 32'h0000_FF00;
               1: mk = 32'h0F00_0000;
               2: mk = 32'h0;
               default: mk = 32'hFFFF_FFFF;
            endcase
            req(kind, o, $urandom, mk, "R10");
         end
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule